// File: doc/BRIEF.md
# Triggered integration window controller

This block follows a decimation filter and turns its stream of results into averaged measurements that are framed by a trigger. A selected edge of the trigger starts a measurement. The block asks the upstream filter to clear itself, throws away a set number of filter results so that the filter's settling time is blanked, and then sums a set number of results. Each complete sum is scaled by a fixed right shift of 6 and then published.

Two modes decide how long the measurement lasts. In fixed-window mode the block runs a set number of back-to-back integrations and then stops until the next start edge. In variable-window mode it keeps integrating while the trigger stays at its active level. The opposite edge then closes the window and drops any partial sum. In that case the last complete result stays on the output.

Top module: `intwin_ctrl`

## Requirements
- R1: After reset, res_o is 0, and res_valid_o and flt_clr_o are low.
- R2: The start edge is chosen by cfg_edge_i: 0 selects a rising edge of trig_i, 1 selects a falling edge. The other edge, seen while the block is idle, has no effect and causes no flt_clr_o pulse.
- R3: A start edge is accepted in any state. flt_clr_o is high for one cycle in the cycle after the clock edge that sees the trigger change. Any partial sum is dropped, and a flt_valid_i result in that same cycle is ignored.
- R4: After a start, the first cfg_discard_i valid filter results are ignored. A value of 0 begins the integration at once.
- R5: Each integration sums cfg_count_i+1 valid results (1 to 64). The published value is the sum arithmetically shifted right by 6, whatever the count. res_o is updated and res_valid_o is high for one cycle, in the cycle after the clock edge that samples the last result of the group.
- R6: The accumulator does not overflow. 64 results of -32768 give -32768, and 64 results of 32767 give 32767.
- R7: With cfg_var_i=0, the block runs cfg_loops_i+1 integrations back to back, with no discard between them, and then stops. Further valid results and the return of the trigger produce no output until the next start edge.
- R8: With cfg_var_i=1, integrations repeat while the trigger stays active. The closing edge pulses flt_clr_o one cycle later and drops the partial sum, and no further results are published.
- R9: res_o holds its last published value whenever res_valid_o is low.
- R10: Cycles in which flt_valid_i is low do not count toward the discard or the integration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_edge_i | input | 1 | Start edge: 0 rising, 1 falling |
| cfg_var_i | input | 1 | 1 selects variable-window mode |
| cfg_discard_i | input | DISC_W | Number of results discarded after a start |
| cfg_count_i | input | 6 | Number of results per integration, minus one |
| cfg_loops_i | input | LOOP_W | Number of integrations in fixed mode, minus one |
| trig_i | input | 1 | Trigger, synchronous to clk_i |
| flt_data_i | input | DATA_W | Signed filter result |
| flt_valid_i | input | 1 | Filter result strobe |
| res_o | output | DATA_W | Signed integration result |
| res_valid_o | output | 1 | One-cycle strobe for a new result |
| flt_clr_o | output | 1 | One-cycle request to clear the filter |

## Verification
Every output is one register stage from its cause. flt_clr_o is due one cycle after the clock edge that sees the trigger change. res_o and res_valid_o are due one cycle after the clock edge that samples the last result of a group. The bench drives inputs on the falling clock edge and checks outputs on the falling edge that follows each rising edge. It therefore checks each flt_clr_o pulse exactly one cycle after its trigger change. Expected results are queued when a window is scheduled, and a monitor pops one for every res_valid_o it sees. Any early, late, extra or missing result therefore shows up as a mismatch, or as a queue that is not empty at the end of a scenario.

// File: rtl/intwin_pkg.sv
package intwin_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_DISCARD   = 2'd1,
    ST_INTEGRATE = 2'd2,
    ST_DONE      = 2'd3
  } intwin_state_e;
endpackage

// File: rtl/intwin_edge.sv
module intwin_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_edge_i,
  input  logic trig_i,
  output logic start_o,
  output logic stop_o
);
  logic trig_q, rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= trig_i;
  end

  assign rise    = trig_i & ~trig_q;
  assign fall    = ~trig_i & trig_q;
  assign start_o = cfg_edge_i ? fall : rise;
  assign stop_o  = cfg_edge_i ? rise : fall;
endmodule

// File: rtl/intwin_seq.sv
module intwin_seq
  import intwin_pkg::*;
#(
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned DISC_W = 8,
  parameter int unsigned LOOP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              flt_valid_i,
  input  logic              cfg_var_i,
  input  logic [DISC_W-1:0] cfg_discard_i,
  input  logic [CNT_W-1:0]  cfg_count_i,
  input  logic [LOOP_W-1:0] cfg_loops_i,
  output intwin_state_e     state_o,
  output logic              acc_clr_o,
  output logic              acc_add_o,
  output logic              publish_o,
  output logic              clr_req_o
);
  intwin_state_e     state_q, state_d;
  logic [DISC_W-1:0] disc_q, disc_d;
  logic [CNT_W-1:0]  int_q, int_d;
  logic [LOOP_W-1:0] loop_q, loop_d;
  logic              active, close;

  assign active = (state_q == ST_DISCARD) || (state_q == ST_INTEGRATE);
  assign close  = cfg_var_i & stop_i & active;

  always_comb begin
    state_d   = state_q;
    disc_d    = disc_q;
    int_d     = int_q;
    loop_d    = loop_q;
    acc_clr_o = 1'b0;
    acc_add_o = 1'b0;
    publish_o = 1'b0;
    clr_req_o = start_i | close;
    if (start_i) begin
      // restart wins over everything in any state
      state_d   = (cfg_discard_i == '0) ? ST_INTEGRATE : ST_DISCARD;
      disc_d    = '0;
      int_d     = '0;
      loop_d    = '0;
      acc_clr_o = 1'b1;
    end else if (close) begin
      state_d   = ST_DONE;
      acc_clr_o = 1'b1;
    end else begin
      unique case (state_q)
        ST_DISCARD: if (flt_valid_i) begin
          if (disc_q == cfg_discard_i - DISC_W'(1)) begin
            state_d = ST_INTEGRATE;
            disc_d  = '0;
          end else begin
            disc_d = disc_q + DISC_W'(1);
          end
        end
        ST_INTEGRATE: if (flt_valid_i) begin
          acc_add_o = 1'b1;
          if (int_q == cfg_count_i) begin
            publish_o = 1'b1;
            int_d     = '0;
            if (!cfg_var_i) begin
              if (loop_q == cfg_loops_i) state_d = ST_DONE;
              else                       loop_d  = loop_q + LOOP_W'(1);
            end
          end else begin
            int_d = int_q + CNT_W'(1);
          end
        end
        ST_DONE:  state_d = ST_IDLE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      disc_q  <= '0;
      int_q   <= '0;
      loop_q  <= '0;
    end else begin
      state_q <= state_d;
      disc_q  <= disc_d;
      int_q   <= int_d;
      loop_q  <= loop_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/intwin_acc.sv
module intwin_acc #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SHIFT  = 6,
  localparam int unsigned ACC_W = DATA_W + SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              add_i,
  input  logic              publish_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] res_o,
  output logic              res_valid_o
);
  logic signed [ACC_W-1:0] acc_q, sum;

  assign sum = acc_q + ACC_W'($signed(data_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q       <= '0;
      res_o       <= '0;
      res_valid_o <= 1'b0;
    end else begin
      res_valid_o <= publish_i;
      if (clr_i)      acc_q <= '0;
      else if (add_i) acc_q <= publish_i ? '0 : sum;
      // fixed scaling: keep the upper DATA_W bits of the sum
      if (publish_i)  res_o <= sum[ACC_W-1:SHIFT];
    end
  end
endmodule

// File: rtl/intwin_ctrl.sv
module intwin_ctrl
  import intwin_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned MAX_INT = 64,
  parameter int unsigned DISC_W  = 8,
  parameter int unsigned LOOP_W  = 8,
  localparam int unsigned CNT_W  = $clog2(MAX_INT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_edge_i,
  input  logic              cfg_var_i,
  input  logic [DISC_W-1:0] cfg_discard_i,
  input  logic [CNT_W-1:0]  cfg_count_i,
  input  logic [LOOP_W-1:0] cfg_loops_i,
  input  logic              trig_i,
  input  logic [DATA_W-1:0] flt_data_i,
  input  logic              flt_valid_i,
  output logic [DATA_W-1:0] res_o,
  output logic              res_valid_o,
  output logic              flt_clr_o
);
  intwin_state_e state;
  logic start, stop, acc_clr, acc_add, publish, clr_req;

  intwin_edge i_edge (
    .clk_i, .rst_ni, .cfg_edge_i, .trig_i,
    .start_o (start),
    .stop_o  (stop)
  );

  intwin_seq #(.CNT_W(CNT_W), .DISC_W(DISC_W), .LOOP_W(LOOP_W)) i_seq (
    .clk_i, .rst_ni,
    .start_i     (start),
    .stop_i      (stop),
    .flt_valid_i,
    .cfg_var_i, .cfg_discard_i, .cfg_count_i, .cfg_loops_i,
    .state_o     (state),
    .acc_clr_o   (acc_clr),
    .acc_add_o   (acc_add),
    .publish_o   (publish),
    .clr_req_o   (clr_req)
  );

  intwin_acc #(.DATA_W(DATA_W), .SHIFT(CNT_W)) i_acc (
    .clk_i, .rst_ni,
    .clr_i       (acc_clr),
    .add_i       (acc_add),
    .publish_i   (publish),
    .data_i      (flt_data_i),
    .res_o,
    .res_valid_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flt_clr_o <= 1'b0;
    else         flt_clr_o <= clr_req;
  end
endmodule

// File: rtl/intwin_chk.sv
module intwin_chk
  import intwin_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              flt_valid_i,
  input logic [DATA_W-1:0] res_o,
  input logic              res_valid_o,
  input logic              flt_clr_o,
  input intwin_state_e     state_i
);
  // R3, R8: a clear request never coincides with a publication
  assert_clr_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(res_valid_o && flt_clr_o));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> $stable(res_o));

  assert_valid_src_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(flt_valid_i));

  assert_from_integ_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(state_i) == ST_INTEGRATE);

  assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_DONE |=> state_i != ST_INTEGRATE && state_i != ST_DONE);
endmodule

bind intwin_ctrl intwin_chk #(.DATA_W(DATA_W)) i_intwin_chk (
  .clk_i, .rst_ni, .flt_valid_i, .res_o, .res_valid_o, .flt_clr_o,
  .state_i (state)
);

// File: tb/test_intwin_ctrl.sv
`timescale 1ns/1ps
module test_intwin_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_edge = 1'b0, cfg_var = 1'b0;
  logic [7:0]  cfg_discard = '0, cfg_loops = '0;
  logic [5:0]  cfg_count = '0;
  logic        trig = 1'b0, valid = 1'b0;
  logic [15:0] data = '0;
  logic [15:0] res;
  logic        res_valid, flt_clr;

  int checks = 0, errors = 0;
  int exp_q[$];
  int last_exp = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  intwin_ctrl i_intwin_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cfg_edge_i(cfg_edge), .cfg_var_i(cfg_var),
    .cfg_discard_i(cfg_discard), .cfg_count_i(cfg_count), .cfg_loops_i(cfg_loops),
    .trig_i(trig), .flt_data_i(data), .flt_valid_i(valid),
    .res_o(res), .res_valid_o(res_valid), .flt_clr_o(flt_clr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pops one expected result per published result
  always @(negedge clk) begin
    if (rst_n && res_valid && !finished) begin
      if (exp_q.size() == 0) begin
        chk(0, "R5 unexpected result", int'($signed(res)), 0);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(int'($signed(res)) == e, "R5 result value", int'($signed(res)), e);
      end
    end
  end

  task automatic send(input logic v, input int d);
    @(negedge clk);
    valid = v;
    data  = d[15:0];
  endtask

  // trigger change with a junk valid sample in the same cycle; check clear pulse
  task automatic set_trig(input logic lvl, input bit exp_clr, input string req);
    @(negedge clk);
    trig  = lvl;
    valid = 1'b1;
    data  = 16'h7abc;
    @(negedge clk);
    valid = 1'b0;
    chk(flt_clr == exp_clr, req, int'(flt_clr), int'(exp_clr));
  endtask

  function automatic int gen(input int kind, input int i);
    case (kind)
      0: return (i < 3) ? 30000 : 1000;
      1: return ((i * 7919) % 60000) - 30000;
      2: return -32768;
      3: return 32767;
      default: return -(i * 37) - 5;
    endcase
  endfunction

  task automatic run(input int disc, input int cnt, input int loops, input bit var_m,
                     input int n, input int kind, input bit gaps);
    int sum = 0;
    bit act;
    for (int i = 0; i < n; i++) begin
      int k;
      if (i < disc) continue;
      k = i - disc;
      if (!var_m && (k / cnt) >= loops) break;
      sum += gen(kind, i);
      if (k % cnt == cnt - 1) begin
        int r;
        r = sum >>> 6;
        exp_q.push_back(r);
        last_exp = r;
        sum = 0;
      end
    end
    cfg_discard = 8'(disc);
    cfg_count   = 6'(cnt - 1);
    cfg_loops   = 8'(loops - 1);
    cfg_var     = var_m;
    act = ~cfg_edge;
    set_trig(act, 1, "R3 clear on start");
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 3 == 1)) send(0, 0);
      send(1, gen(kind, i));
    end
    repeat (3) send(0, 0);
    if (var_m) begin
      set_trig(~act, 1, "R8 clear on window close");
      for (int i = 0; i < 70; i++) send(1, 500);
      repeat (3) send(0, 0);
    end else begin
      for (int i = 0; i < 70; i++) send(1, 500);
      set_trig(~act, 0, "R2 R7 trigger return ignored");
      repeat (3) send(0, 0);
    end
    chk(exp_q.size() == 0, var_m ? "R8 result count" : "R7 result count", exp_q.size(), 0);
    chk(int'($signed(res)) == last_exp, "R9 result held", int'($signed(res)), last_exp);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(res == 0, "R1 reset res", int'(res), 0);
    chk(res_valid == 0, "R1 reset valid", int'(res_valid), 0);
    chk(flt_clr == 0, "R1 reset clear", int'(flt_clr), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run(3, 64, 1, 0, 67, 0, 0);   // R4 discard, R5 single integration
    run(0, 4, 3, 0, 14, 4, 1);    // R10 gaps, R5 floor on negatives, R7 loops
    run(2, 64, 1, 0, 66, 2, 0);   // R6 negative full scale
    run(2, 64, 1, 0, 66, 3, 0);   // R6 positive full scale
    run(0, 64, 2, 0, 128, 1, 0);  // R5 varied data, R7 two loops

    // R2: falling-edge start; idle rise must not start anything
    cfg_edge = 1'b1;
    set_trig(1'b1, 0, "R2 wrong edge ignored");
    repeat (3) send(1, 100);
    chk(res_valid == 0 && exp_q.size() == 0, "R2 no output", int'(res_valid), 0);
    run(1, 8, 2, 0, 17, 1, 0);

    // R8 variable window with rising start
    set_trig(1'b0, 1, "R2 falling start");
    repeat (3) send(0, 0);
    cfg_edge = 1'b0;
    run(1, 4, 1, 1, 15, 1, 1);

    // R3 restart drops the partial sum
    cfg_discard = 8'd0; cfg_count = 6'd7; cfg_loops = 8'd0; cfg_var = 1'b0;
    set_trig(1'b1, 1, "R3 first start");
    for (int i = 0; i < 5; i++) send(1, 1000);
    set_trig(1'b0, 0, "R7 return ignored mid run");
    exp_q.push_back(80);
    last_exp = 80;
    set_trig(1'b1, 1, "R3 restart clear");
    for (int i = 0; i < 8; i++) send(1, 640);
    repeat (3) send(0, 0);
    chk(exp_q.size() == 0, "R3 restart result count", exp_q.size(), 0);
    chk(int'($signed(res)) == 80, "R3 restart value", int'($signed(res)), 80);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule